// File: doc/BRIEF.md
# User-Level Line Permission Fault Unit

This block adds two user-controlled permission bits to every line of a small cache tag array. One bit traps loads and the other traps stores. Each load or store is looked up against the array. If the access hits a line whose matching bit is set and checking is enabled, the block reports a user-level fault one cycle later, with the line address and the access type. A faulting store is not allowed to write cache data.

User code changes the bits with set and clear commands. Before any bit changes, the block asks the coherence side for exclusive ownership of the line. It holds that request until a grant comes back, and it stalls further commands while it waits. Permission bits are kept in a sideband store indexed by line address. A line that is replaced or evicted writes its bits there, and a refill reads them back. A command aimed at a line that is not resident updates the sideband copy instead. A single enable input turns all checking off, for example while a software transaction runs.

Top module: `lpf_unit`

## Requirements
- R1: A command carries a 2-bit mask in which bit 0 selects the fault-on-read bit and bit 1 selects the fault-on-write bit. A set command (cmd_set=1) ORs the mask into the line's bits, and a clear command (cmd_set=0) clears the masked bits. Tracking a software read uses mask 2'b10, and tracking a software write uses 2'b11.
- R2: A load that hits a line with the fault-on-read bit set raises fault_valid in the cycle after the access. In that cycle fault_addr holds the accessed line address and fault_is_write is 0.
- R3: A store that hits a line with the fault-on-write bit set raises fault_valid with fault_is_write=1, and store_commit stays low.
- R4: A store to a line that has only the fault-on-read bit set does not fault. A load to a line that has only the fault-on-write bit set does not fault. A store that hits and does not fault drives store_commit high in the cycle after the access.
- R5: An access that misses reports acc_hit=0, never faults and never commits.
- R6: While check_en is low, no access faults. Hits are still reported, and stores that hit still commit.
- R7: An accepted command raises own_req with own_addr equal to the command's line in the next cycle. Both stay unchanged until own_gnt is seen. The line's bits keep their old value until the grant.
- R8: cmd_done pulses for exactly one cycle, in the cycle after own_gnt is sampled with own_req high. The new bits apply to accesses from that cycle onward.
- R9: cmd_ready is low while an ownership request is pending. A command held on the inputs during that time is accepted only after the pending one completes.
- R10: When a line is replaced by a refill or evicted, its bits are saved in the sideband store. A later refill of that line restores them.
- R11: A command to a line that is not resident updates the sideband copy, and a later refill of that line brings the new bits.
- R12: After reset every line's bits are clear, no fault is reported, cmd_ready is high, and own_req and cmd_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| check_en | input | 1 | Permission checking enable |
| acc_valid | input | 1 | Access lookup strobe |
| acc_write | input | 1 | Access is a store (1) or load (0) |
| acc_addr | input | LINE_AW | Line address of the access |
| fill_valid | input | 1 | Refill a line into its set |
| fill_addr | input | LINE_AW | Line address being refilled |
| evict_valid | input | 1 | Evict a line if resident |
| evict_addr | input | LINE_AW | Line address being evicted |
| cmd_valid | input | 1 | Permission command strobe |
| cmd_set | input | 1 | 1 = set masked bits, 0 = clear them |
| cmd_mask | input | 2 | Bit 0 fault-on-read, bit 1 fault-on-write |
| cmd_addr | input | LINE_AW | Line address of the command |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_done | output | 1 | One-cycle completion pulse |
| own_req | output | 1 | Exclusive ownership request |
| own_addr | output | LINE_AW | Line address of the ownership request |
| own_gnt | input | 1 | Exclusive ownership granted |
| resp_valid | output | 1 | Access result valid |
| acc_hit | output | 1 | Access hit a resident line |
| fault_valid | output | 1 | Access raised a permission fault |
| fault_addr | output | LINE_AW | Line address of the reported access |
| fault_is_write | output | 1 | Reported access was a store |
| store_commit | output | 1 | Store hit and may update data |

## Verification
The lookup is tried with loads and stores against each of the four bit states on a resident line, against a missing line that shares the set, and with checking disabled. These patterns separate read-bit decoding from write-bit decoding, and they separate hit detection from permission checking. Accesses issued while an ownership request waits show whether the bits change early. A command held back behind a pending one shows the stall order. Refill and eviction sequences move a line out and back, and one command targets a line that is not resident. Both cases test whether the bits persist through the sideband store and are not simply reset.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  // Per-line permission pair; bit 0 traps loads, bit 1 traps stores.
  typedef struct packed {
    logic on_wr;
    logic on_rd;
  } perm_t;

  typedef enum logic {
    CMD_IDLE = 1'b0,
    CMD_WAIT = 1'b1
  } cmd_state_e;

  function automatic perm_t perm_merge(perm_t old_p, logic do_set, logic [1:0] mask);
    logic [1:0] v;
    v = old_p;
    if (do_set) v = v | mask;
    else        v = v & ~mask;
    return perm_t'(v);
  endfunction

endpackage

// File: rtl/lpf_tag_array.sv
module lpf_tag_array
  import lpf_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_we,
  input  logic [IDX_W-1:0]            fill_idx,
  input  logic [TAG_W-1:0]            fill_tag,
  input  perm_t                       fill_perm,
  input  logic                        upd_we,
  input  logic [IDX_W-1:0]            upd_idx,
  input  perm_t                       upd_perm,
  input  logic                        inv_we,
  input  logic [IDX_W-1:0]            inv_idx,
  output logic [(1<<IDX_W)-1:0]       valid_o,
  output logic [(1<<IDX_W)-1:0][TAG_W-1:0] tag_o,
  output perm_t [(1<<IDX_W)-1:0]      perm_o
);

  localparam int SETS = 1 << IDX_W;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             v_q, v_d;
    logic [TAG_W-1:0] t_q, t_d;
    perm_t            p_q, p_d;
    logic             ld;

    always_comb begin
      v_d = v_q;
      t_d = t_q;
      p_d = p_q;
      ld  = 1'b0;
      if (fill_we && (fill_idx == IDX_W'(s))) begin
        v_d = 1'b1;
        t_d = fill_tag;
        p_d = fill_perm;
        ld  = 1'b1;
      end else if (upd_we && (upd_idx == IDX_W'(s))) begin
        p_d = upd_perm;
        ld  = 1'b1;
      end else if (inv_we && (inv_idx == IDX_W'(s))) begin
        v_d = 1'b0;
        p_d = '0;
        ld  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else if (ld) begin
        v_q <= v_d;
        t_q <= t_d;
        p_q <= p_d;
      end
    end

    assign valid_o[s] = v_q;
    assign tag_o[s]   = t_q;
    assign perm_o[s]  = p_q;
  end

endmodule

// File: rtl/lpf_sideband.sv
module lpf_sideband
  import lpf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  perm_t         a_data,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  perm_t         b_data,
  input  logic [AW-1:0] r0_addr,
  output perm_t         r0_data,
  input  logic [AW-1:0] r1_addr,
  output perm_t         r1_data
);

  localparam int DEPTH = 1 << AW;

  perm_t [DEPTH-1:0] mem;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    perm_t p_q, p_d;
    logic  ld;

    // The command port wins when both ports target one entry.
    always_comb begin
      p_d = p_q;
      ld  = 1'b0;
      if (b_we && (b_addr == AW'(e))) begin
        p_d = b_data;
        ld  = 1'b1;
      end else if (a_we && (a_addr == AW'(e))) begin
        p_d = a_data;
        ld  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  p_q <= '0;
      else if (ld) p_q <= p_d;
    end

    assign mem[e] = p_q;
  end

  assign r0_data = mem[r0_addr];
  assign r1_data = mem[r1_addr];

endmodule

// File: rtl/lpf_cmd_ctrl.sv
module lpf_cmd_ctrl
  import lpf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_set,
  input  logic [1:0]    cmd_mask,
  input  logic [AW-1:0] cmd_addr,
  input  logic          own_gnt,
  output logic          cmd_ready,
  output logic          own_req,
  output logic [AW-1:0] own_addr,
  output logic          apply,
  output logic          ap_set,
  output logic [1:0]    ap_mask,
  output logic          cmd_done
);

  cmd_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          set_q;
  logic [1:0]    mask_q;
  logic          done_q, done_d;
  logic          accept;

  assign cmd_ready = (state_q == CMD_IDLE);
  assign own_req   = (state_q == CMD_WAIT);
  assign accept    = cmd_valid && cmd_ready;
  assign apply     = own_req && own_gnt;

  always_comb begin
    state_d = state_q;
    done_d  = apply;
    case (state_q)
      CMD_IDLE: if (accept)  state_d = CMD_WAIT;
      CMD_WAIT: if (own_gnt) state_d = CMD_IDLE;
      default:               state_d = CMD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CMD_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      set_q  <= 1'b0;
      mask_q <= '0;
    end else if (accept) begin
      addr_q <= cmd_addr;
      set_q  <= cmd_set;
      mask_q <= cmd_mask;
    end
  end

  assign own_addr = addr_q;
  assign ap_set   = set_q;
  assign ap_mask  = mask_q;
  assign cmd_done = done_q;

endmodule

// File: rtl/lpf_access_check.sv
module lpf_access_check
  import lpf_pkg::*;
(
  input  logic  check_en,
  input  logic  hit,
  input  logic  is_write,
  input  perm_t perm,
  output logic  fault,
  output logic  commit
);

  logic trap;

  always_comb begin
    trap   = is_write ? perm.on_wr : perm.on_rd;
    fault  = hit && check_en && trap;
    commit = hit && is_write && !fault;
  end

endmodule

// File: rtl/lpf_unit.sv
module lpf_unit
  import lpf_pkg::*;
#(
  parameter int LINE_AW = 6,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               check_en,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [LINE_AW-1:0] acc_addr,
  input  logic               fill_valid,
  input  logic [LINE_AW-1:0] fill_addr,
  input  logic               evict_valid,
  input  logic [LINE_AW-1:0] evict_addr,
  input  logic               cmd_valid,
  input  logic               cmd_set,
  input  logic [1:0]         cmd_mask,
  input  logic [LINE_AW-1:0] cmd_addr,
  output logic               cmd_ready,
  output logic               cmd_done,
  output logic               own_req,
  output logic [LINE_AW-1:0] own_addr,
  input  logic               own_gnt,
  output logic               resp_valid,
  output logic               acc_hit,
  output logic               fault_valid,
  output logic [LINE_AW-1:0] fault_addr,
  output logic               fault_is_write,
  output logic               store_commit
);

  localparam int TAG_W = LINE_AW - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  // Tag array view
  logic [SETS-1:0]            tv;
  logic [SETS-1:0][TAG_W-1:0] tt;
  perm_t [SETS-1:0]           tp;

  // Refill and eviction
  logic [IDX_W-1:0] f_idx, e_idx;
  logic [TAG_W-1:0] f_tag, e_tag;
  logic             f_res, e_res, fill_go, f_spill, ev_go;
  perm_t            sb_fill;

  // Sideband spill port
  logic               spill_we;
  logic [LINE_AW-1:0] spill_addr;
  perm_t              spill_perm;

  // Command apply
  logic             apply, ap_set;
  logic [1:0]       ap_mask;
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  logic             c_res;
  perm_t            sb_cmd, c_old, c_new;

  // Access path
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  logic             a_hit, a_fault, a_commit;

  always_comb begin
    f_idx   = fill_addr[IDX_W-1:0];
    f_tag   = fill_addr[LINE_AW-1:IDX_W];
    f_res   = tv[f_idx] && (tt[f_idx] == f_tag);
    fill_go = fill_valid && !f_res;
    f_spill = fill_go && tv[f_idx];

    e_idx   = evict_addr[IDX_W-1:0];
    e_tag   = evict_addr[LINE_AW-1:IDX_W];
    e_res   = tv[e_idx] && (tt[e_idx] == e_tag);
    ev_go   = evict_valid && e_res && !fill_go;

    spill_we   = f_spill || ev_go;
    spill_addr = f_spill ? {tt[f_idx], f_idx} : evict_addr;
    spill_perm = f_spill ? tp[f_idx] : tp[e_idx];
  end

  always_comb begin
    c_idx = own_addr[IDX_W-1:0];
    c_tag = own_addr[LINE_AW-1:IDX_W];
    c_res = tv[c_idx] && (tt[c_idx] == c_tag);
    c_old = c_res ? tp[c_idx] : sb_cmd;
    c_new = perm_merge(c_old, ap_set, ap_mask);
  end

  always_comb begin
    a_idx = acc_addr[IDX_W-1:0];
    a_tag = acc_addr[LINE_AW-1:IDX_W];
    a_hit = tv[a_idx] && (tt[a_idx] == a_tag);
  end

  lpf_tag_array #(
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_we  (fill_go),
    .fill_idx (f_idx),
    .fill_tag (f_tag),
    .fill_perm(sb_fill),
    .upd_we   (apply && c_res),
    .upd_idx  (c_idx),
    .upd_perm (c_new),
    .inv_we   (ev_go),
    .inv_idx  (e_idx),
    .valid_o  (tv),
    .tag_o    (tt),
    .perm_o   (tp)
  );

  lpf_sideband #(
    .AW(LINE_AW)
  ) u_side (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_we   (spill_we),
    .a_addr (spill_addr),
    .a_data (spill_perm),
    .b_we   (apply && !c_res),
    .b_addr (own_addr),
    .b_data (c_new),
    .r0_addr(fill_addr),
    .r0_data(sb_fill),
    .r1_addr(own_addr),
    .r1_data(sb_cmd)
  );

  lpf_cmd_ctrl #(
    .AW(LINE_AW)
  ) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_set  (cmd_set),
    .cmd_mask (cmd_mask),
    .cmd_addr (cmd_addr),
    .own_gnt  (own_gnt),
    .cmd_ready(cmd_ready),
    .own_req  (own_req),
    .own_addr (own_addr),
    .apply    (apply),
    .ap_set   (ap_set),
    .ap_mask  (ap_mask),
    .cmd_done (cmd_done)
  );

  lpf_access_check u_chk_path (
    .check_en(check_en),
    .hit     (a_hit),
    .is_write(acc_write),
    .perm    (tp[a_idx]),
    .fault   (a_fault),
    .commit  (a_commit)
  );

  // Access result registers
  logic               rv_q, rv_d, hit_q, hit_d, flt_q, flt_d, com_q, com_d;
  logic               wr_q;
  logic [LINE_AW-1:0] fa_q;

  always_comb begin
    rv_d  = acc_valid;
    hit_d = acc_valid && a_hit;
    flt_d = acc_valid && a_fault;
    com_d = acc_valid && a_commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      hit_q <= 1'b0;
      flt_q <= 1'b0;
      com_q <= 1'b0;
    end else begin
      rv_q  <= rv_d;
      hit_q <= hit_d;
      flt_q <= flt_d;
      com_q <= com_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= '0;
      wr_q <= 1'b0;
    end else if (acc_valid) begin
      fa_q <= acc_addr;
      wr_q <= acc_write;
    end
  end

  assign resp_valid     = rv_q;
  assign acc_hit        = hit_q;
  assign fault_valid    = flt_q;
  assign fault_addr     = fa_q;
  assign fault_is_write = wr_q;
  assign store_commit   = com_q;

endmodule

// File: rtl/lpf_unit_checker.sv
module lpf_unit_checker #(
  parameter int LINE_AW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               check_en,
  input logic               acc_valid,
  input logic               cmd_ready,
  input logic               cmd_done,
  input logic               own_req,
  input logic               own_gnt,
  input logic [LINE_AW-1:0] own_addr,
  input logic               acc_hit,
  input logic               fault_valid,
  input logic               store_commit
);

  a_r8_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    own_req && own_gnt |=> cmd_done);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  a_r9_stall_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    own_req |-> !cmd_ready);

  a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    own_req && !own_gnt |=> own_req && $stable(own_addr));

  a_r6_no_fault_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !check_en |=> !fault_valid);

  a_r3_fault_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !store_commit);

  a_r5_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> acc_hit);

endmodule

bind lpf_unit lpf_unit_checker #(.LINE_AW(LINE_AW)) u_lpf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .check_en    (check_en),
  .acc_valid   (acc_valid),
  .cmd_ready   (cmd_ready),
  .cmd_done    (cmd_done),
  .own_req     (own_req),
  .own_gnt     (own_gnt),
  .own_addr    (own_addr),
  .acc_hit     (acc_hit),
  .fault_valid (fault_valid),
  .store_commit(store_commit)
);

// File: tb/lpf_unit_test.sv
`timescale 1ns/1ps
module lpf_unit_test;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          check_en, acc_valid, acc_write, fill_valid, evict_valid;
  logic [AW-1:0] acc_addr, fill_addr, evict_addr, cmd_addr;
  logic          cmd_valid, cmd_set, own_gnt;
  logic [1:0]    cmd_mask;
  logic          cmd_ready, cmd_done, own_req, resp_valid, acc_hit;
  logic          fault_valid, fault_is_write, store_commit;
  logic [AW-1:0] own_addr, fault_addr;

  always #2.5 clk = ~clk;

  lpf_unit #(.LINE_AW(AW), .IDX_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .check_en(check_en),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_mask(cmd_mask), .cmd_addr(cmd_addr),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done), .own_req(own_req), .own_addr(own_addr),
    .own_gnt(own_gnt), .resp_valid(resp_valid), .acc_hit(acc_hit),
    .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_is_write(fault_is_write), .store_commit(store_commit)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: compares each access result against the scoreboard.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (resp_valid) begin
        if (exp_q.size() == 0) check("scoreboard empty", 32'd1, 32'd0);
        else check(req_q.pop_front(),
                   {22'd0, acc_hit, fault_valid, fault_is_write, store_commit, fault_addr},
                   exp_q.pop_front());
      end else if (fault_valid) begin
        check("R2 spurious fault", 32'd1, 32'd0);
      end
    end
  end

  // Driver: one access; expected result pushed to the scoreboard.
  task automatic do_access(logic [AW-1:0] a, logic wr, logic hit, logic flt, string req);
    logic com;
    com = hit && wr && !flt;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    exp_q.push_back({22'd0, hit, flt, wr, com, a});
    req_q.push_back(req);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_fill(logic [AW-1:0] a);
    @(negedge clk); fill_valid = 1'b1; fill_addr = a;
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic do_evict(logic [AW-1:0] a);
    @(negedge clk); evict_valid = 1'b1; evict_addr = a;
    @(negedge clk); evict_valid = 1'b0;
  endtask

  task automatic cmd_start(logic [AW-1:0] a, logic s, logic [1:0] m);
    @(negedge clk);
    check("R9 ready before command", {31'd0, cmd_ready}, 32'd1);
    cmd_valid = 1'b1; cmd_set = s; cmd_mask = m; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R7 own_req raised", {31'd0, own_req}, 32'd1);
    check("R7 own_addr", {26'd0, own_addr}, {26'd0, a});
  endtask

  task automatic cmd_grant();
    own_gnt = 1'b1;
    @(negedge clk);
    own_gnt = 1'b0;
    check("R8 done pulse", {30'd0, cmd_done, own_req}, 32'b10);
    @(negedge clk);
    check("R8 done one cycle", {31'd0, cmd_done}, 32'd0);
  endtask

  task automatic do_cmd(logic [AW-1:0] a, logic s, logic [1:0] m);
    cmd_start(a, s, m);
    @(negedge clk);
    cmd_grant();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; check_en = 1'b1;
    acc_valid = 0; acc_write = 0; acc_addr = '0;
    fill_valid = 0; fill_addr = '0; evict_valid = 0; evict_addr = '0;
    cmd_valid = 0; cmd_set = 0; cmd_mask = '0; cmd_addr = '0; own_gnt = 0;
    repeat (3) @(negedge clk);
    check("R12 reset outputs",
          {27'd0, cmd_ready, own_req, cmd_done, fault_valid, store_commit}, 32'b10000);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: fresh line has clear bits
    do_fill(6'h05);
    do_access(6'h05, 1'b0, 1'b1, 1'b0, "R12 load clear line");
    do_access(6'h05, 1'b1, 1'b1, 1'b0, "R12 store clear line");
    // R5: same set, other tag
    do_access(6'h09, 1'b0, 1'b0, 1'b0, "R5 load miss");
    do_access(6'h09, 1'b1, 1'b0, 1'b0, "R5 store miss");

    // R7: bits unchanged while ownership pending (R1 mask 2'b10 = software read)
    cmd_start(6'h05, 1'b1, 2'b10);
    repeat (2) @(negedge clk);
    check("R7 request held", {25'd0, own_req, own_addr}, {25'd0, 1'b1, 6'h05});
    check("R9 not ready while pending", {31'd0, cmd_ready}, 32'd0);
    do_access(6'h05, 1'b1, 1'b1, 1'b0, "R7 store before grant");
    cmd_grant();
    do_access(6'h05, 1'b1, 1'b1, 1'b1, "R3 store to write-trap line");
    do_access(6'h05, 1'b0, 1'b1, 1'b0, "R4 load to write-only line");

    // R1: set read bit -> both set
    do_cmd(6'h05, 1'b1, 2'b01);
    do_access(6'h05, 1'b0, 1'b1, 1'b1, "R2 load to read-trap line");
    do_access(6'h05, 1'b1, 1'b1, 1'b1, "R1 store after set both");
    // R1: clear write bit -> read only
    do_cmd(6'h05, 1'b0, 2'b10);
    do_access(6'h05, 1'b1, 1'b1, 1'b0, "R4 store to read-only line");
    do_access(6'h05, 1'b0, 1'b1, 1'b1, "R2 load after clear write bit");

    // R6: checking disabled
    @(negedge clk); check_en = 1'b0;
    do_access(6'h05, 1'b0, 1'b1, 1'b0, "R6 load with checks off");
    @(negedge clk); check_en = 1'b1;

    // R10: replacement and eviction keep bits
    do_fill(6'h09);
    do_access(6'h09, 1'b0, 1'b1, 1'b0, "R10 new line clear");
    do_access(6'h05, 1'b0, 1'b0, 1'b0, "R10 replaced line misses");
    do_fill(6'h05);
    do_access(6'h05, 1'b0, 1'b1, 1'b1, "R10 bits restored on refill");
    do_evict(6'h05);
    do_access(6'h05, 1'b0, 1'b0, 1'b0, "R10 evicted line misses");
    do_fill(6'h05);
    do_access(6'h05, 1'b0, 1'b1, 1'b1, "R10 bits restored after evict");

    // R11: command to non-resident line (mask 2'b11 = software write)
    do_cmd(6'h22, 1'b1, 2'b11);
    do_access(6'h22, 1'b0, 1'b0, 1'b0, "R11 still not resident");
    do_fill(6'h22);
    do_access(6'h22, 1'b1, 1'b1, 1'b1, "R11 store after refill");
    do_access(6'h22, 1'b0, 1'b1, 1'b1, "R11 load after refill");

    // R9: second command held until first completes
    cmd_start(6'h05, 1'b1, 2'b10);
    cmd_valid = 1'b1; cmd_set = 1'b0; cmd_mask = 2'b11; cmd_addr = 6'h22;
    repeat (2) @(negedge clk);
    check("R9 held command stalls", {25'd0, cmd_ready, own_addr}, {25'd0, 1'b0, 6'h05});
    own_gnt = 1'b1;
    @(negedge clk);
    own_gnt = 1'b0;
    check("R8 first done", {31'd0, cmd_done}, 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 held command accepted", {25'd0, own_req, own_addr}, {25'd0, 1'b1, 6'h22});
    cmd_grant();
    do_access(6'h22, 1'b1, 1'b1, 1'b0, "R9 second command applied");
    do_access(6'h05, 1'b1, 1'b1, 1'b1, "R9 first command applied");

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule